// File: doc/BRIEF.md
# Armed Trigger Source Selector with Phase Capture

This block picks one of four asynchronous trigger lines with a 2-bit select code. It turns the rising edge of the chosen line into a one-cycle event pulse. A trigger is accepted only once after each arm request. When an armed trigger arrives, the block stores the value of a free-running phase counter in a capture register and raises a triggered status flag. That flag stays high until the block is armed again.

The trigger lines are a board trigger, a remote-bus trigger, a CPU-driven software trigger line and a source burst trigger. The CPU fires a software trigger by pulling its line low and then releasing it high, and only the low-to-high step counts. An arm strobe and an active-low override input control arming. While the override is held low, the block re-arms itself after every capture, which is used during self-test. In normal operation the override is held high.

The control is a three-state machine:
- `ST_IDLE` is the state after reset.
- `ST_ARMED` waits for a trigger event.
- `ST_FIRED` holds the captured result.

Its transitions are:
- *arm*: any state goes to `ST_ARMED` when `arm_req` is high, and `ST_IDLE` or `ST_FIRED` goes to `ST_ARMED` when `ovr_arm_n` is low.
- *fire*: `ST_ARMED` goes to `ST_FIRED` on a selected event while `arm_req` is low.
- *hold*: in every other case the state stays where it is.

Top module: `trig_capture_unit`

## Requirements
- R1: Select code 0 routes `trg_board`, 1 routes `trg_remote`, 2 routes `trg_soft` and 3 routes `trg_burst`. Edges on the other three lines have no effect on `trig_out`, `triggered` or `cap_count`.
- R2: Each line passes through a two-stage synchronizer. A trigger event is only a low-to-high change on the synchronized line; a high-to-low change produces nothing. If the line rises before clock edge k, `trig_out` is high for exactly one cycle, after edge k+1.
- R3: A high `arm_req` at a clock edge moves the machine to `ST_ARMED`, and `triggered` is low after that edge.
- R4: A selected event at the edge where the machine is in `ST_ARMED` and `arm_req` is low does three things. It moves the machine to `ST_FIRED`, it sets `triggered` high, and it loads `cap_count` with the phase counter value held just before that edge.
- R5: Events that arrive in `ST_IDLE` or `ST_FIRED` are ignored. `triggered` keeps its value and `cap_count` does not change, so at most one capture happens per arm cycle.
- R6: When `arm_req` and an event occur at the same edge, arming wins. `triggered` is low afterwards, `cap_count` is unchanged, and the machine stays in `ST_ARMED`.
- R7: The phase counter is 16 bits wide. It is 0 after reset, increments on every clock edge and wraps from 16'hFFFF to 0.
- R8: While `ovr_arm_n` is low, `ST_IDLE` and `ST_FIRED` move to `ST_ARMED` at the next edge. This means `triggered` is high for one cycle after each capture and then low again.
- R9: Synchronous active-high `rst` puts the machine in `ST_IDLE`. It clears `triggered`, `cap_count`, the phase counter and the synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Trigger source select code |
| trg_board | input | 1 | Board trigger line, asynchronous |
| trg_remote | input | 1 | Remote-bus trigger line, asynchronous |
| trg_soft | input | 1 | CPU-driven software trigger line, asynchronous |
| trg_burst | input | 1 | Source burst trigger line, asynchronous |
| arm_req | input | 1 | Arm strobe, synchronous |
| ovr_arm_n | input | 1 | Active-low self-test arm override; hold high in normal use |
| trig_out | output | 1 | One-cycle pulse for a rising edge on the selected line |
| triggered | output | 1 | High once a trigger has been captured since the last arm |
| cap_count | output | 16 | Phase counter value captured at the trigger |

## Verification
The bench walks each select code with its own line rising, which proves the routing and the capture timing. It then sends edges on a mismatched line, which must leave the status untouched and so separates routing from the mere presence of an edge. A repeated edge after a capture, with and without a fresh arm, separates the once-per-arm rule from plain edge capture. A falling software edge, an arm in the same cycle as the event, the self-test override, a capture across the counter wrap, and a trigger after reset with no arm each target one ordering rule that the plain patterns cannot reveal.

// File: rtl/trig_sel_pkg.sv
package trig_sel_pkg;
    localparam int unsigned SRC_CNT = 4;
    localparam int unsigned SEL_W   = $clog2(SRC_CNT);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRED = 2'd2
    } arm_state_e;
endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_async};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/trig_phase_cnt.sv
module trig_phase_cnt #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] phase
);
    always_ff @(posedge clk) begin
        if (rst) phase <= '0;
        else     phase <= phase + 1'b1;
    end
endmodule

// File: rtl/trig_arm_fsm.sv
module trig_arm_fsm
    import trig_sel_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_req,
    input  logic             ovr_arm_n,
    input  logic             evt,
    input  logic [CNT_W-1:0] phase,
    output logic             armed,
    output logic             triggered,
    output logic [CNT_W-1:0] cap_count
);
    arm_state_e state_q, state_d;
    logic       arm_go;
    logic       take;

    assign arm_go = arm_req | ~ovr_arm_n;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (arm_go) state_d = ST_ARMED;
            ST_ARMED: begin
                if (arm_req)  state_d = ST_ARMED;
                else if (evt) state_d = ST_FIRED;
            end
            ST_FIRED: if (arm_go) state_d = ST_ARMED;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign take = (state_q == ST_ARMED) && evt && !arm_req;

    always_ff @(posedge clk) begin
        if (rst)       cap_count <= '0;
        else if (take) cap_count <= phase;
    end

    always_comb begin
        armed     = (state_q == ST_ARMED);
        triggered = (state_q == ST_FIRED);
    end
endmodule

// File: rtl/trig_capture_unit.sv
module trig_capture_unit
    import trig_sel_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       src_sel,
    input  logic             trg_board,
    input  logic             trg_remote,
    input  logic             trg_soft,
    input  logic             trg_burst,
    input  logic             arm_req,
    input  logic             ovr_arm_n,
    output logic             trig_out,
    output logic             triggered,
    output logic [CNT_W-1:0] cap_count
);
    logic [SRC_CNT-1:0] pins;
    logic [SRC_CNT-1:0] rise_vec;
    logic [CNT_W-1:0]   phase_q;
    logic               armed;

    assign pins = {trg_burst, trg_soft, trg_remote, trg_board};

    for (genvar g = 0; g < SRC_CNT; g++) begin : g_sync
        trig_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk       (clk),
            .rst       (rst),
            .pin_async (pins[g]),
            .rise      (rise_vec[g])
        );
    end

    assign trig_out = rise_vec[src_sel];

    trig_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .phase (phase_q)
    );

    trig_arm_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .arm_req   (arm_req),
        .ovr_arm_n (ovr_arm_n),
        .evt       (trig_out),
        .phase     (phase_q),
        .armed     (armed),
        .triggered (triggered),
        .cap_count (cap_count)
    );
endmodule

// File: rtl/trig_capture_chk.sv
module trig_capture_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       src_sel,
    input logic             arm_req,
    input logic             ovr_arm_n,
    input logic             trig_out,
    input logic             triggered,
    input logic [CNT_W-1:0] cap_count,
    input logic [CNT_W-1:0] phase,
    input logic             armed
);
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        trig_out |=> (!trig_out || (src_sel != $past(src_sel)))); // R2
    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
        arm_req |=> !triggered); // R3
    AST_FIRE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (armed && trig_out && !arm_req) |=> (triggered && cap_count == $past(phase))); // R4
    AST_IGNORE_UNARMED: assert property (@(posedge clk) disable iff (rst)
        !armed |=> $stable(cap_count)); // R5
    AST_ARM_WINS: assert property (@(posedge clk) disable iff (rst)
        (arm_req && trig_out) |=> (!triggered && $stable(cap_count))); // R6
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (phase == CNT_W'($past(phase) + 1'b1))); // R7
    AST_OVR_REARM: assert property (@(posedge clk) disable iff (rst)
        (!ovr_arm_n && !armed) |=> armed); // R8
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!triggered && cap_count == '0 && phase == '0)); // R9
endmodule

bind trig_capture_unit trig_capture_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_sel   (src_sel),
    .arm_req   (arm_req),
    .ovr_arm_n (ovr_arm_n),
    .trig_out  (trig_out),
    .triggered (triggered),
    .cap_count (cap_count),
    .phase     (phase_q),
    .armed     (armed)
);

// File: tb/test_trig_capture_unit.sv
module test_trig_capture_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  src_sel = 2'd0;
    logic [3:0]  pins = 4'd0;
    logic        arm_req = 1'b0;
    logic        ovr_arm_n = 1'b1;
    logic        trig_out;
    logic        triggered;
    logic [15:0] cap_count;
    logic [15:0] cyc = 16'd0;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    // bench cycle count since reset, equal to the phase counter by R7
    always @(posedge clk) cyc <= rst ? 16'd0 : cyc + 16'd1;

    trig_capture_unit i_trig_capture_unit (
        .clk(clk), .rst(rst), .src_sel(src_sel),
        .trg_board(pins[0]), .trg_remote(pins[1]),
        .trg_soft(pins[2]), .trg_burst(pins[3]),
        .arm_req(arm_req), .ovr_arm_n(ovr_arm_n),
        .trig_out(trig_out), .triggered(triggered), .cap_count(cap_count)
    );

    // {arm, sel[1:0], line[1:0], exp_triggered, exp_new_capture}
    localparam logic [6:0] VEC [9] = '{
        7'b1_00_00_1_1, // R1 board
        7'b1_01_01_1_1, // R1 remote
        7'b1_10_10_1_1, // R1 soft
        7'b1_11_11_1_1, // R1 burst
        7'b1_10_00_0_0, // R1 unselected line
        7'b1_01_11_0_0, // R1 unselected line
        7'b0_11_11_1_1, // R4 still armed
        7'b0_11_11_1_0, // R5 second event ignored
        7'b0_00_00_1_0  // R5 fired, other line ignored
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_arm();
        @(negedge clk) arm_req = 1'b1;
        @(negedge clk) arm_req = 1'b0;
        chk(triggered == 1'b0, "R3", triggered, 0);
    endtask

    task automatic pulse(input int line, input bit exp_out, input bit exp_trig,
                         input bit exp_new, input string req);
        logic [15:0] old;
        logic [15:0] c;
        old = cap_count;
        pins[line] = 1'b1;
        c = cyc;
        @(negedge clk);
        @(negedge clk);
        chk(trig_out == exp_out, {req, " trig_out"}, trig_out, exp_out);
        @(negedge clk);
        chk(triggered == exp_trig, {req, " triggered"}, triggered, exp_trig);
        if (exp_new) chk(cap_count == c + 16'd2, {req, " capture"}, cap_count, c + 16'd2);
        else         chk(cap_count == old, {req, " capture held"}, cap_count, old);
        pins[line] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] old;
        repeat (3) @(negedge clk);
        chk(triggered == 1'b0 && cap_count == 16'd0 && trig_out == 1'b0, "R9 reset", {triggered, cap_count}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        for (int i = 0; i < 9; i++) begin
            logic [6:0] v;
            v = VEC[i];
            src_sel = v[5:4];
            if (v[6]) do_arm();
            else @(negedge clk);
            pulse(int'(v[3:2]), v[5:4] == v[3:2], v[1], v[0], "R1/R4/R5 vec");
        end

        // R2: falling edge of software line is no event
        src_sel = 2'd0;
        pins[2] = 1'b1;
        repeat (4) @(negedge clk);
        do_arm();
        src_sel = 2'd2;
        pins[2] = 1'b0;
        repeat (5) @(negedge clk);
        chk(triggered == 1'b0, "R2 falling edge", triggered, 0);
        pulse(2, 1'b1, 1'b1, 1'b1, "R2 rising edge");

        // R6: arm in the same cycle as the event
        do_arm();
        src_sel = 2'd1;
        old = cap_count;
        pins[1] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        arm_req = 1'b1;
        @(negedge clk);
        arm_req = 1'b0;
        chk(triggered == 1'b0, "R6 triggered", triggered, 0);
        chk(cap_count == old, "R6 capture", cap_count, old);
        pins[1] = 1'b0;
        repeat (4) @(negedge clk);
        pulse(1, 1'b1, 1'b1, 1'b1, "R6 still armed");

        // R8: override re-arms
        ovr_arm_n = 1'b0;
        @(negedge clk);
        chk(triggered == 1'b0, "R8 rearm", triggered, 0);
        pins[1] = 1'b1;
        begin
            logic [15:0] c;
            c = cyc;
            repeat (3) @(negedge clk);
            chk(triggered == 1'b1, "R8 fire", triggered, 1);
            chk(cap_count == c + 16'd2, "R8 capture", cap_count, c + 16'd2);
            @(negedge clk);
            chk(triggered == 1'b0, "R8 auto rearm", triggered, 0);
        end
        pins[1] = 1'b0;
        ovr_arm_n = 1'b1;
        repeat (4) @(negedge clk);

        // R9: reset clears, then R5 unarmed event ignored
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(triggered == 1'b0 && cap_count == 16'd0, "R9 clear", {triggered, cap_count}, 0);
        src_sel = 2'd3;
        pulse(3, 1'b1, 1'b0, 1'b0, "R5 idle");

        // R7: capture across counter wrap
        do_arm();
        while (cyc != 16'hFFFE) @(negedge clk);
        pulse(3, 1'b1, 1'b1, 1'b1, "R7 wrap");
        chk(cap_count == 16'h0000, "R7 wrap value", cap_count, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule